// File: doc/BRIEF.md
# Virtual Address Segment Classifier

This block takes one 64-bit virtual address per request and decides how the memory system must treat it. The address falls into one of three classes: a region that goes through the translation lookaside buffer (TLB), a region with a fixed translation to a physical address and a cached or uncached attribute, or an illegal region. The block works in either 64-bit or 32-bit addressing mode. In 32-bit mode only the low word of the address is decoded.

For TLB-mapped regions, the requester supplies the result code of an external TLB lookup with the request. The block turns that code, together with the access direction, into an encoded exception cause, and returns the faulting address alongside it. A probe-only request returns the same classification and a failure flag, but it never raises an exception. The TLB, the caches and exception vectoring are handled outside this block.

A two-state machine sequences each response: `ST_IDLE` moves to `ST_RESP` on a request (transition "accept"). `ST_RESP` stays in `ST_RESP` on a back-to-back request (transition "stream") and returns to `ST_IDLE` when no request arrives (transition "drain").

Top module: `vseg_classifier`

## Requirements
- R1: In 64-bit mode, the address goes through the TLB (`resp_use_tlb`=1, `resp_paddr`=0, `resp_cached`=0) in two cases. The first is when bits [63:40] equal 0x000000, 0x400000 or 0xC00000. The second is when bits [63:40] are all ones and bits [39:29] equal 0x7FE or 0x7FF.
- R2: In 64-bit mode, when bits [63:40] are all ones and bits [39:29] equal 0x7FC, the response is direct and cached, with `resp_paddr` = address bits [28:0] zero-extended.
- R3: In 64-bit mode, when bits [63:40] are all ones and bits [39:29] equal 0x7FD, the response is direct and uncached, with `resp_paddr` = address bits [28:0] zero-extended.
- R4: In 64-bit mode, when bits [63:62]=2'b10 and bits [58:40] are zero, the response is direct with `resp_paddr` = address bits [35:0]. It is uncached when bits [61:59] equal 2 and cached for any other value.
- R5: Any other 64-bit address is an address error: `resp_fail`=1, `resp_use_tlb`=0, cause 4 for a load or 5 for a store.
- R6: In 32-bit mode, bits [31:29] select the region and bits [63:32] are ignored. Values 0-3, 6 and 7 go through the TLB. Value 4 is direct and cached, and value 5 is direct and uncached. Both direct regions take `resp_paddr` = bits [28:0].
- R7: For TLB-mapped regions, `tlb_result` is encoded as 0 = hit, 1 = miss, 2 = invalid and 3 = modified. A miss or invalid result gives cause 2 for a load or 3 for a store. A modified result gives cause 1. A hit gives cause 0 and no failure. `tlb_result` is ignored for direct regions.
- R8: A probe-only request sets `resp_fail` on any failure but keeps `resp_exc_valid`=0, `resp_exc_cause`=0 and `resp_badvaddr`=0.
- R9: `resp_valid` rises exactly one cycle after each `req_valid` cycle, and back-to-back requests give back-to-back responses. When an exception is signalled, `resp_badvaddr` holds the request address; otherwise it is 0.
- R10: After reset, and in every cycle without a response, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_mode64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| req_store | input | 1 | 1 = store, 0 = load |
| req_probe | input | 1 | Probe-only translation, no exception |
| tlb_result | input | 2 | External TLB result code |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | 36 | Physical address for direct regions |
| resp_cached | output | 1 | Cached attribute for direct regions |
| resp_use_tlb | output | 1 | Address is TLB-mapped |
| resp_fail | output | 1 | Translation failed |
| resp_exc_valid | output | 1 | Exception signalled |
| resp_exc_cause | output | 5 | Exception cause code |
| resp_badvaddr | output | 64 | Faulting address |

## Verification
Every result of this block is due one clock edge after the request cycle. The bench drives each request on a falling edge and samples all response fields on the following falling edge, so exactly one rising edge lies in between. For back-to-back traffic, each response is read in the same half-cycle in which the next request is driven. A final idle falling edge confirms that `resp_valid` and all fields have returned to zero.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
    localparam int VA_W     = 64;
    localparam int CAUSE_W  = 5;
    localparam int COMPAT_W = 29;   // offset width of the fixed compatibility windows

    typedef enum logic [1:0] {
        TLB_HIT      = 2'd0,
        TLB_MISS     = 2'd1,
        TLB_INVALID  = 2'd2,
        TLB_MODIFIED = 2'd3
    } tlb_res_e;

    typedef enum logic [1:0] {
        SEG_MAPPED = 2'd0,
        SEG_DIRECT = 2'd1,
        SEG_BAD    = 2'd2
    } seg_kind_e;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_MOD  = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_TLBL = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_TLBS = 5'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_ADEL = 5'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_ADES = 5'd5;
endpackage

// File: rtl/vseg_region_dec.sv
module vseg_region_dec
    import vseg_pkg::*;
#(
    parameter int PA_W         = 36,
    parameter int CCA_LSB      = 59,
    parameter int CCA_W        = 3,
    parameter int CCA_UNCACHED = 2
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            mode64,
    output seg_kind_e       kind,
    output logic            cached,
    output logic [PA_W-1:0] paddr
);
    localparam int REGION_LSB = 40;
    localparam int REGION_W   = VA_W - REGION_LSB;
    localparam int SUB_W      = REGION_LSB - COMPAT_W;
    localparam int WIN_ZERO_W = CCA_LSB - REGION_LSB;

    logic [REGION_W-1:0] region;
    logic [SUB_W-1:0]    sub_zone;
    logic [2:0]          seg32;
    logic [CCA_W-1:0]    cca;
    logic [PA_W-1:0]     compat_pa;
    logic [PA_W-1:0]     window_pa;

    assign region    = vaddr[VA_W-1:REGION_LSB];
    assign sub_zone  = vaddr[REGION_LSB-1:COMPAT_W];
    assign seg32     = vaddr[31:29];
    assign cca       = vaddr[CCA_LSB +: CCA_W];
    assign window_pa = vaddr[PA_W-1:0];

    generate
        if (PA_W > COMPAT_W) begin : g_pad
            assign compat_pa = {{(PA_W-COMPAT_W){1'b0}}, vaddr[COMPAT_W-1:0]};
        end else begin : g_trunc
            assign compat_pa = vaddr[PA_W-1:0];
        end
    endgenerate

    seg_kind_e       kind64, kind32;
    logic            cached64, cached32;
    logic [PA_W-1:0] pa64, pa32;

    always_comb begin
        kind64   = SEG_BAD;
        cached64 = 1'b0;
        pa64     = '0;
        if (region == 24'h000000 || region == 24'h400000 || region == 24'hC00000) begin
            kind64 = SEG_MAPPED;
        end else if (&region) begin
            unique case (sub_zone)
                11'h7FC: begin kind64 = SEG_DIRECT; cached64 = 1'b1; pa64 = compat_pa; end
                11'h7FD: begin kind64 = SEG_DIRECT; cached64 = 1'b0; pa64 = compat_pa; end
                11'h7FE, 11'h7FF: kind64 = SEG_MAPPED;
                default: kind64 = SEG_BAD;
            endcase
        end else if (vaddr[VA_W-1 -: 2] == 2'b10 &&
                     vaddr[REGION_LSB +: WIN_ZERO_W] == '0) begin
            kind64   = SEG_DIRECT;
            cached64 = (cca != CCA_W'(CCA_UNCACHED));
            pa64     = window_pa;
        end
    end

    always_comb begin
        kind32   = SEG_MAPPED;
        cached32 = 1'b0;
        pa32     = '0;
        unique case (seg32)
            3'd4: begin kind32 = SEG_DIRECT; cached32 = 1'b1; pa32 = compat_pa; end
            3'd5: begin kind32 = SEG_DIRECT; cached32 = 1'b0; pa32 = compat_pa; end
            default: kind32 = SEG_MAPPED;
        endcase
    end

    assign kind   = mode64 ? kind64   : kind32;
    assign cached = mode64 ? cached64 : cached32;
    assign paddr  = mode64 ? pa64     : pa32;
endmodule

// File: rtl/vseg_cause_map.sv
module vseg_cause_map
    import vseg_pkg::*;
(
    input  seg_kind_e          kind,
    input  logic               is_store,
    input  logic               probe,
    input  logic [1:0]         tlb_result,
    output logic               use_tlb,
    output logic               fail,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] cause
);
    tlb_res_e           tres;
    logic [CAUSE_W-1:0] raw_cause;

    assign tres = tlb_res_e'(tlb_result);

    always_comb begin
        raw_cause = CAUSE_NONE;
        fail      = 1'b0;
        unique case (kind)
            SEG_BAD: begin
                fail      = 1'b1;
                raw_cause = is_store ? CAUSE_ADES : CAUSE_ADEL;
            end
            SEG_MAPPED: begin
                unique case (tres)
                    TLB_HIT: raw_cause = CAUSE_NONE;
                    TLB_MISS, TLB_INVALID: begin
                        fail      = 1'b1;
                        raw_cause = is_store ? CAUSE_TLBS : CAUSE_TLBL;
                    end
                    TLB_MODIFIED: begin
                        fail      = 1'b1;
                        raw_cause = CAUSE_MOD;
                    end
                endcase
            end
            default: raw_cause = CAUSE_NONE;
        endcase
    end

    assign use_tlb   = (kind == SEG_MAPPED);
    assign exc_valid = fail && !probe;
    assign cause     = exc_valid ? raw_cause : CAUSE_NONE;
endmodule

// File: rtl/vseg_classifier.sv
module vseg_classifier
    import vseg_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [63:0]        req_vaddr,
    input  logic               req_mode64,
    input  logic               req_store,
    input  logic               req_probe,
    input  logic [1:0]         tlb_result,
    output logic               resp_valid,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               resp_cached,
    output logic               resp_use_tlb,
    output logic               resp_fail,
    output logic               resp_exc_valid,
    output logic [CAUSE_W-1:0] resp_exc_cause,
    output logic [63:0]        resp_badvaddr
);
    typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} state_e;

    state_e state_q, state_d;

    seg_kind_e          kind;
    logic               dec_cached, map_use_tlb, map_fail, map_exc;
    logic [PA_W-1:0]    dec_pa;
    logic [CAUSE_W-1:0] map_cause;

    vseg_region_dec #(.PA_W(PA_W)) u_region (
        .vaddr  (req_vaddr),
        .mode64 (req_mode64),
        .kind   (kind),
        .cached (dec_cached),
        .paddr  (dec_pa)
    );

    vseg_cause_map u_cause (
        .kind       (kind),
        .is_store   (req_store),
        .probe      (req_probe),
        .tlb_result (tlb_result),
        .use_tlb    (map_use_tlb),
        .fail       (map_fail),
        .exc_valid  (map_exc),
        .cause      (map_cause)
    );

    // accept: IDLE->RESP, stream: RESP->RESP, drain: RESP->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            resp_paddr     <= '0;
            resp_cached    <= 1'b0;
            resp_use_tlb   <= 1'b0;
            resp_fail      <= 1'b0;
            resp_exc_valid <= 1'b0;
            resp_exc_cause <= CAUSE_NONE;
            resp_badvaddr  <= '0;
        end else begin
            resp_paddr     <= (kind == SEG_DIRECT) ? dec_pa : '0;
            resp_cached    <= (kind == SEG_DIRECT) && dec_cached;
            resp_use_tlb   <= map_use_tlb;
            resp_fail      <= map_fail;
            resp_exc_valid <= map_exc;
            resp_exc_cause <= map_cause;
            resp_badvaddr  <= map_exc ? req_vaddr : '0;
        end
    end

    assign resp_valid = (state_q == ST_RESP);

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_badva_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (resp_exc_valid ? (resp_badvaddr == $past(req_vaddr))
                                       : (resp_badvaddr == '0)));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_fail && !resp_exc_valid && !resp_use_tlb &&
                         resp_exc_cause == '0 && resp_paddr == '0));
    assert_probe_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe) |=> !resp_exc_valid && resp_exc_cause == '0);
    assert_mapped_nopa_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_use_tlb |-> (resp_paddr == '0 && !resp_cached));
    assert_adderr_no_tlb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_exc_cause == CAUSE_ADEL || resp_exc_cause == CAUSE_ADES) |-> !resp_use_tlb);
    assert_exc_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_exc_valid |-> resp_fail);
endmodule

// File: tb/vseg_classifier_tb.sv
module vseg_classifier_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_mode64 = 1'b0;
    logic        req_store = 1'b0;
    logic        req_probe = 1'b0;
    logic [1:0]  tlb_result = '0;
    logic        resp_valid;
    logic [35:0] resp_paddr;
    logic        resp_cached, resp_use_tlb, resp_fail, resp_exc_valid;
    logic [4:0]  resp_exc_cause;
    logic [63:0] resp_badvaddr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vseg_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_mode64(req_mode64), .req_store(req_store), .req_probe(req_probe),
        .tlb_result(tlb_result), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_cached(resp_cached), .resp_use_tlb(resp_use_tlb), .resp_fail(resp_fail),
        .resp_exc_valid(resp_exc_valid), .resp_exc_cause(resp_exc_cause),
        .resp_badvaddr(resp_badvaddr)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_resp(string tag, logic use_tlb, logic cached, logic [35:0] pa,
                               logic fail, logic excv, logic [4:0] cause, logic [63:0] bad);
        chk(tag, "valid",   64'(resp_valid),     64'd1);
        chk(tag, "use_tlb", 64'(resp_use_tlb),   64'(use_tlb));
        chk(tag, "cached",  64'(resp_cached),    64'(cached));
        chk(tag, "paddr",   64'(resp_paddr),     64'(pa));
        chk(tag, "fail",    64'(resp_fail),      64'(fail));
        chk(tag, "exc",     64'(resp_exc_valid), 64'(excv));
        chk(tag, "cause",   64'(resp_exc_cause), 64'(cause));
        chk(tag, "badva",   resp_badvaddr,       bad);
    endtask

    task automatic expect_idle(string tag);
        expect_quiet: begin
            chk(tag, "valid", 64'(resp_valid),     64'd0);
            chk(tag, "fail",  64'(resp_fail),      64'd0);
            chk(tag, "tlb",   64'(resp_use_tlb),   64'd0);
            chk(tag, "cause", 64'(resp_exc_cause), 64'd0);
            chk(tag, "paddr", 64'(resp_paddr),     64'd0);
            chk(tag, "badva", resp_badvaddr,       64'd0);
        end
    endtask

    task automatic drive(logic [63:0] va, logic m64, logic st, logic pr, logic [1:0] tr);
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_mode64 = m64;
        req_store  = st;
        req_probe  = pr;
        tlb_result = tr;
    endtask

    // one request, response sampled one falling edge later
    task automatic issue(logic [63:0] va, logic m64, logic st, logic pr, logic [1:0] tr);
        @(negedge clk);
        drive(va, m64, st, pr, tr);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_idle("R10 reset");
    endtask

    task automatic t_mapped64;
        issue(64'h0000_0012_3456_7000, 1, 0, 0, 0); expect_resp("R1 user", 1, 0, 0, 0, 0, 0, 0);
        issue(64'h4000_0000_0000_1000, 1, 0, 0, 0); expect_resp("R1 super", 1, 0, 0, 0, 0, 0, 0);
        issue(64'hC000_0000_0000_0000, 1, 1, 0, 0); expect_resp("R1 kernel", 1, 0, 0, 0, 0, 0, 0);
        issue(64'hFFFF_FFFF_C000_0000, 1, 0, 0, 0); expect_resp("R1 sub7FE", 1, 0, 0, 0, 0, 0, 0);
        issue(64'hFFFF_FFFF_E000_0000, 1, 0, 0, 0); expect_resp("R1 sub7FF", 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_compat64;
        issue(64'hFFFF_FFFF_8123_4567, 1, 0, 0, 0); expect_resp("R2 cached", 0, 1, 36'h0_0123_4567, 0, 0, 0, 0);
        issue(64'hFFFF_FFFF_BFFF_FFFC, 1, 1, 0, 0); expect_resp("R3 uncached", 0, 0, 36'h0_1FFF_FFFC, 0, 0, 0, 0);
    endtask

    task automatic t_window;
        issue(64'h9000_0001_2345_6789, 1, 0, 0, 0); expect_resp("R4 attr2", 0, 0, 36'h1_2345_6789, 0, 0, 0, 0);
        issue(64'hA800_000F_FFFF_FFF0, 1, 0, 0, 0); expect_resp("R4 attr5", 0, 1, 36'hF_FFFF_FFF0, 0, 0, 0, 0);
        issue(64'h8000_0000_0000_0040, 1, 0, 0, 0); expect_resp("R4 attr0", 0, 1, 36'h0_0000_0040, 0, 0, 0, 0);
    endtask

    task automatic t_addr_err;
        issue(64'h1000_0000_0000_0000, 1, 0, 0, 0); expect_resp("R5 load", 0, 0, 0, 1, 1, 4, 64'h1000_0000_0000_0000);
        issue(64'h1000_0000_0000_0000, 1, 1, 0, 0); expect_resp("R5 store", 0, 0, 0, 1, 1, 5, 64'h1000_0000_0000_0000);
        issue(64'hFFFF_FFFF_0000_0000, 1, 0, 0, 0); expect_resp("R5 subzone", 0, 0, 0, 1, 1, 4, 64'hFFFF_FFFF_0000_0000);
        issue(64'h8000_0100_0000_0000, 1, 1, 0, 0); expect_resp("R5 window hole", 0, 0, 0, 1, 1, 5, 64'h8000_0100_0000_0000);
    endtask

    task automatic t_compat32;
        issue(64'h0000_0000_7FFF_0000, 0, 0, 0, 0); expect_resp("R6 user", 1, 0, 0, 0, 0, 0, 0);
        issue(64'hFFFF_FFFF_8000_1000, 0, 0, 0, 0); expect_resp("R6 seg4", 0, 1, 36'h1000, 0, 0, 0, 0);
        issue(64'h1234_5678_A000_0040, 0, 0, 0, 0); expect_resp("R6 seg5 upper ignored", 0, 0, 36'h40, 0, 0, 0, 0);
        issue(64'h0000_0000_C000_0000, 0, 0, 0, 0); expect_resp("R6 seg6", 1, 0, 0, 0, 0, 0, 0);
        issue(64'h0000_0000_E000_0000, 0, 0, 0, 0); expect_resp("R6 seg7", 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_tlb_causes;
        issue(64'h0000_0000_0000_2000, 1, 0, 0, 1); expect_resp("R7 miss load", 1, 0, 0, 1, 1, 2, 64'h2000);
        issue(64'hC000_0000_0000_3000, 1, 1, 0, 2); expect_resp("R7 invalid store", 1, 0, 0, 1, 1, 3, 64'hC000_0000_0000_3000);
        issue(64'h4000_0000_0000_4000, 1, 1, 0, 3); expect_resp("R7 modified", 1, 0, 0, 1, 1, 1, 64'h4000_0000_0000_4000);
        issue(64'h0000_0000_1000_0000, 0, 0, 0, 1); expect_resp("R7 miss compat", 1, 0, 0, 1, 1, 2, 64'h1000_0000);
        issue(64'hFFFF_FFFF_8000_0100, 1, 0, 0, 1); expect_resp("R7 direct ignores tlb", 0, 1, 36'h100, 0, 0, 0, 0);
    endtask

    task automatic t_probe;
        issue(64'h0000_0000_0000_5000, 1, 0, 1, 1); expect_resp("R8 probe miss", 1, 0, 0, 1, 0, 0, 0);
        issue(64'h1000_0000_0000_0000, 1, 0, 1, 0); expect_resp("R8 probe adderr", 0, 0, 0, 1, 0, 0, 0);
        issue(64'h0000_0000_0000_5000, 1, 0, 1, 0); expect_resp("R8 probe hit", 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_stream;
        @(negedge clk);
        drive(64'hFFFF_FFFF_8000_0010, 1, 0, 0, 0);
        @(negedge clk);
        expect_resp("R9 first", 0, 1, 36'h10, 0, 0, 0, 0);
        drive(64'h2000_0000_0000_0000, 1, 0, 0, 0);
        @(negedge clk);
        expect_resp("R9 second", 0, 0, 0, 1, 1, 4, 64'h2000_0000_0000_0000);
        req_valid = 1'b0;
        @(negedge clk);
        expect_idle("R10 after drain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mapped64();
        t_compat64();
        t_window();
        t_addr_err();
        t_compat32();
        t_tlb_causes();
        t_probe();
        t_stream();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule